// File: doc/BRIEF.md
# Parallel NOR Burst Read Front End

This block is the read side of a 16-bit parallel NOR memory model. It serves words from a small built-in word array to a host that drives chip enable, output enable, an address-valid strobe and an address bus, all sampled on one clock. The data bus is returned as a data word together with a pad enable. Tri-state pad drivers sit outside the block.

After reset the block answers in page mode. An address-valid pulse opens a fixed initial access. After that, any word in the same 16-word page is returned as soon as the low address bits change. A configuration write switches the block to clocked burst mode. In that mode an address-valid pulse starts a burst. WAIT stays high for a programmable number of clocks, and then one word is delivered per clock. The burst is either a fixed length that wraps inside its aligned group, or continuous.

The controller states are `ST_IDLE`, `ST_PG_INIT`, `ST_PG_READ`, `ST_BU_LAT`, `ST_BU_DATA` and `ST_BU_END`. The transitions are as follows:
- Chip enable high or a configuration write forces `ST_IDLE` from any state.
- An address-valid pulse with chip enable low starts a new access from any state:
  - In page mode it goes to `ST_PG_INIT`.
  - In burst mode it goes to `ST_BU_LAT`, or straight to `ST_BU_DATA` when the latency is zero.
- `ST_PG_INIT` moves to `ST_PG_READ` when its counter expires.
- `ST_BU_LAT` moves to `ST_BU_DATA` when its counter expires.
- `ST_BU_DATA` moves to `ST_BU_END` after the last beat of a fixed-length burst.
- All other states hold.

Top module: `nor_burst_reader`

## Requirements
- R1: After reset the block is idle in page mode with burst length code 00 and latency 3: `dvalid`, `wait_o` and `dq_oe` are all 0.
- R2: In page mode, `adv_n` low with `ce_n` low at a clock edge starts an initial access. For INIT_CYC clocks (default 4) `dvalid` is 0. After that, `dq` carries the array word at the addressed location and `dvalid` is 1. The array word at address a is {a[7:0] XOR 8'h5A, a[7:0]}.
- R3: While a page read is open, changing `addr[3:0]` returns the new word in the same cycle, with no new initial access. An address outside the captured page drops `dvalid` to 0.
- R4: A clock edge with `cfg_we` high loads the configuration from `addr[6:0]` and returns the block to idle. The fields are: bit 0 selects burst mode (1) or page mode (0); bits 2:1 give the burst length (00=4, 01=8, 10=16, 11=continuous); bits 6:3 give the latency in clocks.
- R5: In burst mode, `adv_n` low with `ce_n` low starts a burst, also in the middle of a running one. `wait_o` is 1 and `dvalid` is 0 for exactly the programmed latency. With latency 0 the first word appears one clock after the start edge.
- R6: After the latency, one word is delivered per clock with `dvalid` 1 and `wait_o` 0. A fixed burst delivers exactly 4, 8 or 16 words. After that, `dvalid` and `wait_o` are both 0.
- R7: A fixed burst wraps inside the aligned group of its length. Word i comes from (start AND NOT(L-1)) OR ((start+i) AND (L-1)).
- R8: A continuous burst reads linearly from the start address. It wraps from the top of the array to 0 and runs until `ce_n` rises.
- R9: `ce_n` high forces `dvalid`, `wait_o` and `dq_oe` to 0 in the same cycle and ends any access at the next edge. A new access needs a new `adv_n` pulse.
- R10: `oe_n` only gates the pad enable: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| cfg_we | input | 1 | Configuration write strobe; value taken from addr[6:0] |
| addr | input | AW (8) | Word address |
| dq | output | DW (16) | Read data word (0 when not driven) |
| dq_oe | output | 1 | Pad output enable for dq |
| dvalid | output | 1 | Current dq word is valid |
| wait_o | output | 1 | Burst data not yet valid (initial latency) |

## Verification
The assertions check the following on every cycle:
- With chip enable high, all outputs are quiet, and the block is idle one edge later.
- A configuration write always leads to idle.
- WAIT and data-valid are never high together.
- Continuous bursts step the address by exactly one per beat.
- Fixed bursts never leave their aligned group and never exceed their beat count.

Only the bench scenarios can show the following: the exact latency length, the word values in the expected wrap order, the same-cycle page hits, and the restart of a burst by a fresh address strobe.

// File: rtl/nor_burst_pkg.sv
package nor_burst_pkg;

    localparam int LAT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PG_INIT,
        ST_PG_READ,
        ST_BU_LAT,
        ST_BU_DATA,
        ST_BU_END
    } rd_state_t;

    typedef enum logic [1:0] {
        BL_4    = 2'b00,
        BL_8    = 2'b01,
        BL_16   = 2'b10,
        BL_CONT = 2'b11
    } blen_t;

    // Field order fixes the encoding on addr[6:0]: {lat, blen, sync_en}
    typedef struct packed {
        logic [LAT_W-1:0] lat;
        blen_t            blen;
        logic             sync_en;
    } rdcfg_t;

    localparam int CFG_W = $bits(rdcfg_t);

    // index of last beat in a fixed-length burst
    function automatic logic [3:0] blen_last(blen_t b);
        unique case (b)
            BL_4:    return 4'd3;
            BL_8:    return 4'd7;
            BL_16:   return 4'd15;
            default: return 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/nor_cfg_reg.sv
module nor_cfg_reg
    import nor_burst_pkg::*;
#(
    parameter int RST_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] din,
    output rdcfg_t           cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.sync_en <= 1'b0;
            cfg.blen    <= BL_4;
            cfg.lat     <= LAT_W'(RST_LAT);
        end else if (we) begin
            cfg <= rdcfg_t'(din);
        end
    end

endmodule

// File: rtl/nor_word_rom.sv
module nor_word_rom #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // fixed content pattern: high byte = low address byte XOR 5A
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign mem[i] = DW'({8'(i) ^ 8'h5A, 8'(i)});
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nor_burst_addr.sv
module nor_burst_addr
    import nor_burst_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] cur,
    input  blen_t         blen,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    assign inc = cur + 1'b1;

    always_comb begin
        unique case (blen)
            BL_4:    mask = AW'(3);
            BL_8:    mask = AW'(7);
            BL_16:   mask = AW'(15);
            default: mask = '1;
        endcase
    end

    // keep the group bits, advance only the in-group bits
    assign nxt = (cur & ~mask) | (inc & mask);

endmodule

// File: rtl/nor_burst_reader.sv
module nor_burst_reader
    import nor_burst_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int PW       = 4,
    parameter int INIT_CYC = 4,
    parameter int RST_LAT  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          adv_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] dq,
    output logic          dq_oe,
    output logic          dvalid,
    output logic          wait_o
);

    localparam int INIT_W = $clog2(INIT_CYC + 1);
    localparam int CW     = (LAT_W > INIT_W) ? LAT_W : INIT_W;

    rd_state_t         state, state_d;
    logic [CW-1:0]     cnt, cnt_d;
    logic [3:0]        beat, beat_d;
    logic [AW-1:0]     cur, cur_d;
    logic [AW-PW-1:0]  page_q, page_d;

    rdcfg_t            cfg;
    logic [AW-1:0]     nxt;
    logic [AW-1:0]     rd_addr;
    logic [DW-1:0]     rom_q;
    logic              page_hit;

    nor_cfg_reg #(.RST_LAT(RST_LAT)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .din   (addr[CFG_W-1:0]),
        .cfg   (cfg)
    );

    nor_burst_addr #(.AW(AW)) u_seq (
        .cur  (cur),
        .blen (cfg.blen),
        .nxt  (nxt)
    );

    assign rd_addr  = (state == ST_PG_READ) ? {page_q, addr[PW-1:0]} : cur;
    assign page_hit = (addr[AW-1:PW] == page_q);

    nor_word_rom #(.AW(AW), .DW(DW)) u_rom (
        .raddr (rd_addr),
        .rdata (rom_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            beat   <= '0;
            cur    <= '0;
            page_q <= '0;
        end else begin
            state  <= state_d;
            cnt    <= cnt_d;
            beat   <= beat_d;
            cur    <= cur_d;
            page_q <= page_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        beat_d  = beat;
        cur_d   = cur;
        page_d  = page_q;
        if (cfg_we || ce_n) begin
            state_d = ST_IDLE;
        end else if (!adv_n) begin
            cur_d  = addr;
            page_d = addr[AW-1:PW];
            beat_d = '0;
            if (!cfg.sync_en) begin
                state_d = ST_PG_INIT;
                cnt_d   = CW'(INIT_CYC - 1);
            end else if (cfg.lat == '0) begin
                state_d = ST_BU_DATA;
            end else begin
                state_d = ST_BU_LAT;
                cnt_d   = CW'(cfg.lat - 1'b1);
            end
        end else begin
            unique case (state)
                ST_IDLE, ST_PG_READ, ST_BU_END: ;
                ST_PG_INIT: begin
                    if (cnt == '0) state_d = ST_PG_READ;
                    else           cnt_d   = cnt - 1'b1;
                end
                ST_BU_LAT: begin
                    if (cnt == '0) state_d = ST_BU_DATA;
                    else           cnt_d   = cnt - 1'b1;
                end
                ST_BU_DATA: begin
                    cur_d  = nxt;
                    beat_d = beat + 1'b1;
                    if (cfg.blen != BL_CONT && beat == blen_last(cfg.blen))
                        state_d = ST_BU_END;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        dvalid = 1'b0;
        wait_o = 1'b0;
        unique case (state)
            ST_PG_READ: dvalid = !ce_n && page_hit;
            ST_BU_LAT:  wait_o = !ce_n;
            ST_BU_DATA: dvalid = !ce_n;
            default: ;
        endcase
        dq_oe = !ce_n && !oe_n;
        dq    = dq_oe ? rom_q : '0;
    end

endmodule

// File: rtl/nor_burst_chk.sv
module nor_burst_chk
    import nor_burst_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          adv_n,
    input logic          cfg_we,
    input logic          dvalid,
    input logic          wait_o,
    input logic          dq_oe,
    input rd_state_t     state,
    input logic [AW-1:0] cur,
    input logic [3:0]    beat,
    input blen_t         blen
);

    logic [AW-1:0] grp_mask;
    always_comb begin
        unique case (blen)
            BL_4:    grp_mask = AW'(3);
            BL_8:    grp_mask = AW'(7);
            BL_16:   grp_mask = AW'(15);
            default: grp_mask = '0;
        endcase
    end

    p_quiet_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!dvalid && !wait_o && !dq_oe));

    p_idle_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (state == ST_IDLE));

    p_cfg_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (state == ST_IDLE));

    p_wait_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> !dvalid);

    p_cont_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BU_DATA && blen == BL_CONT && !ce_n && adv_n && !cfg_we)
        |=> (cur == AW'($past(cur) + 1'b1)));

    p_wrap_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BU_DATA && blen != BL_CONT && !ce_n && adv_n && !cfg_we)
        |=> ((cur | grp_mask) == ($past(cur) | grp_mask)));

    p_beat_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BU_DATA && blen != BL_CONT) |-> (beat <= blen_last(blen)));

endmodule

bind nor_burst_reader nor_burst_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .adv_n  (adv_n),
    .cfg_we (cfg_we),
    .dvalid (dvalid),
    .wait_o (wait_o),
    .dq_oe  (dq_oe),
    .state  (state),
    .cur    (cur),
    .beat   (beat),
    .blen   (cfg.blen)
);

// File: tb/sim_nor_burst_reader.sv
module sim_nor_burst_reader;

    localparam int INIT_CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1, cfg_we = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] dq;
    logic        dq_oe, dvalid, wait_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    nor_burst_reader u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n),
        .cfg_we(cfg_we), .addr(addr), .dq(dq), .dq_oe(dq_oe),
        .dvalid(dvalid), .wait_o(wait_o)
    );

    // {sync, blen[1:0], lat[3:0], start[7:0]}
    localparam logic [14:0] VEC [6] = '{
        {1'b1, 2'b00, 4'd3, 8'h05},
        {1'b1, 2'b01, 4'd2, 8'h1E},
        {1'b1, 2'b10, 4'd0, 8'h2B},
        {1'b1, 2'b11, 4'd1, 8'hFD},
        {1'b1, 2'b00, 4'd5, 8'h80},
        {1'b1, 2'b01, 4'd1, 8'h47}
    };

    function automatic logic [15:0] word_of(logic [7:0] a);
        return {a ^ 8'h5A, a};
    endfunction

    function automatic logic [7:0] beat_addr(logic [7:0] s, logic [1:0] bl, int i);
        logic [7:0] l;
        if (bl == 2'b11) return 8'(s + i);
        l = 8'(4 << bl);
        return (s & ~(l - 8'd1)) | (8'(s + i) & (l - 8'd1));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(logic [6:0] v);
        ce_n = 1'b1; cfg_we = 1'b1; addr = {1'b0, v};
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic run_burst(logic [7:0] s, logic [1:0] bl, logic [3:0] lat, int nbeats);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = s;
        tick();
        adv_n = 1'b1; addr = 8'hC3;
        for (int i = 0; i < lat; i++) begin
            check("R5 wait during latency", {wait_o, dvalid}, 2'b10);
            tick();
        end
        for (int i = 0; i < nbeats; i++) begin
            check("R6 beat valid", {dvalid, wait_o}, 2'b10);
            check(bl == 2'b11 ? "R8 continuous word" : "R7 wrapped word",
                  dq, word_of(beat_addr(s, bl, i)));
            tick();
        end
        if (bl != 2'b11)
            check("R6 burst ended", {dvalid, wait_o}, 2'b00);
        ce_n = 1'b1;
        #1;
        check("R9 ce high quiet", {dvalid, wait_o, dq_oe}, 3'b000);
        tick();
    endtask

    task automatic run_page(logic [7:0] a);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = a;
        tick();
        adv_n = 1'b1;
        for (int i = 0; i < INIT_CYC; i++) begin
            check("R2 initial access", dvalid, 1'b0);
            tick();
        end
        check("R2 first page word valid", dvalid, 1'b1);
        check("R2 first page word", dq, word_of(a));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {dvalid, wait_o, dq_oe}, 3'b000);
        rst_n = 1'b1;
        tick();
        check("R1 idle after reset", {dvalid, wait_o, dq_oe}, 3'b000);

        // page mode is the reset default
        run_page(8'h37);
        addr = 8'h3A; #1;
        check("R3 page hit word", dq, word_of(8'h3A));
        check("R3 page hit valid", dvalid, 1'b1);
        addr = 8'h30; #1;
        check("R3 page hit low", dq, word_of(8'h30));
        tick();
        addr = 8'h3F; #1;
        check("R3 page hit high", dq, word_of(8'h3F));
        addr = 8'h47; #1;
        check("R3 off page not valid", dvalid, 1'b0);
        addr = 8'h31; oe_n = 1'b1; #1;
        check("R10 oe high releases pads", dq_oe, 1'b0);
        check("R10 oe high keeps valid", dvalid, 1'b1);
        oe_n = 1'b0; #1;
        check("R10 oe low drives pads", dq_oe, 1'b1);
        ce_n = 1'b1; #1;
        check("R9 ce high quiet page", {dvalid, dq_oe}, 2'b00);
        tick();

        // vector table of bursts
        for (int v = 0; v < 6; v++) begin
            logic [1:0] bl;
            logic [3:0] lat;
            logic [7:0] s;
            int n;
            bl  = VEC[v][13:12];
            lat = VEC[v][11:8];
            s   = VEC[v][7:0];
            n   = (bl == 2'b11) ? 20 : (4 << bl);
            cfg_write({lat, bl, VEC[v][14]});
            run_burst(s, bl, lat, n);
        end

        // R5 restart mid-burst: continuous, latency 1
        cfg_write({4'd1, 2'b11, 1'b1});
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 8'h10;
        tick();
        adv_n = 1'b1;
        tick(); tick(); tick();
        check("R8 continuous third word", dq, word_of(8'h12));
        adv_n = 1'b0; addr = 8'h90;
        tick();
        adv_n = 1'b1;
        check("R5 restart wait", {wait_o, dvalid}, 2'b10);
        tick();
        check("R5 restart first word", dq, word_of(8'h90));
        check("R5 restart valid", dvalid, 1'b1);

        // R4 config write mid-burst returns to idle
        cfg_we = 1'b1; addr = 8'h00;
        tick();
        cfg_we = 1'b0; addr = 8'h22;
        #1;
        check("R4 config write idles", {dvalid, wait_o}, 2'b00);
        tick();
        check("R9 no access without adv", {dvalid, wait_o}, 2'b00);
        ce_n = 1'b1;
        tick();

        // R4 back in page mode after writing mode bit 0
        run_page(8'hA9);
        addr = 8'hA2; #1;
        check("R4 page mode again", dq, word_of(8'hA2));
        ce_n = 1'b1;
        tick();

        // R5 latency zero on a fixed burst of 4
        cfg_write({4'd0, 2'b00, 1'b1});
        run_burst(8'hF6, 2'b00, 4'd0, 4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule